// File: doc/BRIEF.md
# MSI Capability State Register Bank

This block keeps the message-signalled-interrupt capability state of an endpoint for a configurable number of physical functions (up to sixteen). For each function it stores an interrupt enable bit, a three-bit multiple-message field that encodes how many vectors the host granted, a 32-bit per-vector mask and a 32-bit per-vector pending word. The enable bits and the multiple-message fields are exported at all times as flat vectors, so interrupt-generation logic can see each function's grant without a lookup.

Two writers touch the state. A configuration-write port stands in for host configuration cycles. It writes either a control word (enable and multiple-message field) or a mask word to one function. User logic sets the pending words through a strobe-qualified, function-tagged port. A select input reads back one function's mask and pending words with a fixed latency of one cycle. A single-cycle notification pulse tells user logic that the mask of an enabled function has actually changed value.

Top module: `msi_cap_bank`

## Requirements
- R1: Reset (rst_n low) clears every enable bit, multiple-message field, mask word and pending word to zero, and holds mask_upd_o, mask_rdata_o and pend_rdata_o at zero.
- R2: A control write is a cycle with cfg_wr_en_i=1 and cfg_wr_kind_i=0. It sets the addressed function's enable from cfg_wr_data_i[0] and its multiple-message code from cfg_wr_data_i[3:1]. From the next cycle the enable appears on msi_en_o[f] and the code on mme_o[3f+2:3f]. Function f's field is at bits [3f+2:3f], so function 0 is at [2:0] and function 1 at [5:3].
- R3: Multiple-message codes 0 to 5 (1, 2, 4, 8, 16 and 32 vectors) are stored unchanged. Codes 6 and 7 are stored as 5. No field of mme_o ever holds 6 or 7.
- R4: A mask write is a cycle with cfg_wr_en_i=1 and cfg_wr_kind_i=1. It stores cfg_wr_data_i as the addressed function's 32-bit mask.
- R5: The value on mask_sel_i at a clock edge selects a function. From the following cycle mask_rdata_o shows that function's mask and pend_rdata_o shows its pending word.
- R6: A mask write to a function whose enable is 1, with data that differs from the stored mask, drives mask_upd_o high for exactly the one cycle that follows the write.
- R7: A mask write whose data equals the stored mask, or a mask write to a function whose enable is 0, gives no pulse on mask_upd_o. In the second case the new mask is still stored.
- R8: When pend_we_i is 1 for a cycle, pend_data_i is stored as the pending word of the function given by pend_fn_i.
- R9: A pending strobe or a configuration write whose function index is NUM_FN or more changes no state. A select index of NUM_FN or more reads zero on both read outputs.
- R10: A write to one function leaves the enable, multiple-message field, mask and pending word of every other function unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en_i | input | 1 | Configuration write strobe |
| cfg_wr_kind_i | input | 1 | 0 = control word, 1 = mask word |
| cfg_wr_fn_i | input | FN_IDX_W | Target function of a configuration write |
| cfg_wr_data_i | input | VEC_W | Write data: control in bits [3:0], or the full mask |
| pend_we_i | input | 1 | Pending-word update strobe |
| pend_fn_i | input | FN_IDX_W | Target function of a pending update |
| pend_data_i | input | VEC_W | New pending word |
| mask_sel_i | input | FN_IDX_W | Function selected for read-back |
| msi_en_o | output | NUM_FN | Enable bit of each function |
| mme_o | output | 3*NUM_FN | Packed multiple-message codes, 3 bits per function |
| mask_rdata_o | output | VEC_W | Mask of the selected function, one cycle after selection |
| pend_rdata_o | output | VEC_W | Pending word of the selected function, one cycle after selection |
| mask_upd_o | output | 1 | One-cycle pulse on a change to an enabled function's mask |

## Verification
Wrong state in a function's control registers shows on msi_en_o or mme_o in the cycle right after the write that caused it. It also shows on every later cycle, because these vectors are exported continuously. Wrong state in a mask or pending word stays hidden until that function is selected, and it then shows one cycle after selection. For this reason every function, including the indices beyond NUM_FN, is swept through the select port after each write phase. A faulty change detector shows on mask_upd_o one cycle after the offending mask write: either a missing pulse, a pulse on a repeated value or on a disabled function, or a pulse that lasts more than one cycle.

// File: rtl/msi_cap_pkg.sv
// Package: msi_cap_pkg
// Shared constants, write-kind encoding and the multiple-message clamp.
// Assumes the multiple-message field is 3 bits wide and that code 5 (32
// vectors) is the largest legal grant.
package msi_cap_pkg;

    localparam int unsigned MME_W = 3;
    localparam logic [MME_W-1:0] MME_MAX = 3'd5;

    typedef enum logic {
        WK_CTRL = 1'b0,
        WK_MASK = 1'b1
    } wr_kind_e;

    // Map the illegal codes 6 and 7 onto the largest legal grant.
    function automatic logic [MME_W-1:0] mme_clamp(input logic [MME_W-1:0] code);
        return (code > MME_MAX) ? MME_MAX : code;
    endfunction

endpackage

// File: rtl/msi_cfg_decode.sv
// Module: msi_cfg_decode
// Turns the configuration-write port and the pending-update port into
// one-hot per-function write strobes, and prepares the control fields.
// Assumes: a function index of NUM_FN or more matches no function, so the
// write is dropped. Purely combinational.
module msi_cfg_decode
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_FN   = 12,
    parameter int unsigned FN_IDX_W = 4
) (
    input  logic                wr_en,
    input  logic                wr_kind,
    input  logic [FN_IDX_W-1:0] wr_fn,
    input  logic [3:0]          ctrl_field,
    input  logic                pend_we,
    input  logic [FN_IDX_W-1:0] pend_fn,
    output logic [NUM_FN-1:0]   ctrl_hit,
    output logic [NUM_FN-1:0]   mask_hit,
    output logic [NUM_FN-1:0]   pend_hit,
    output logic                ctrl_en,
    output logic [MME_W-1:0]    ctrl_mme
);

    wr_kind_e kind;

    // Interpret the raw kind bit as the enumerated write kind.
    always_comb kind = wr_kind_e'(wr_kind);

    // Extract the enable bit and the clamped multiple-message code.
    always_comb begin
        ctrl_en  = ctrl_field[0];
        ctrl_mme = mme_clamp(ctrl_field[3:1]);
    end

    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        // Compare the target index with this function's own index.
        always_comb begin
            ctrl_hit[g] = wr_en && (kind == WK_CTRL) && (wr_fn == FN_IDX_W'(g));
            mask_hit[g] = wr_en && (kind == WK_MASK) && (wr_fn == FN_IDX_W'(g));
            pend_hit[g] = pend_we && (pend_fn == FN_IDX_W'(g));
        end
    end

endmodule

// File: rtl/msi_fn_slice.sv
// Module: msi_fn_slice
// Holds the capability state of one function: enable, multiple-message
// code, mask and pending word. It flags a mask write that would change an
// enabled function's mask.
// Assumes: at most one of ctrl_hit and mask_hit is high in a cycle.
module msi_fn_slice
    import msi_cap_pkg::*;
#(
    parameter int unsigned VEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_hit,
    input  logic             mask_hit,
    input  logic             pend_hit,
    input  logic             en_d,
    input  logic [MME_W-1:0] mme_d,
    input  logic [VEC_W-1:0] mask_d,
    input  logic [VEC_W-1:0] pend_d,
    output logic             en_q,
    output logic [MME_W-1:0] mme_q,
    output logic [VEC_W-1:0] mask_q,
    output logic [VEC_W-1:0] pend_q,
    output logic             mask_chg
);

    // Control register: enable bit and multiple-message code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            mme_q <= '0;
        end else if (ctrl_hit) begin
            en_q  <= en_d;
            mme_q <= mme_d;
        end
    end

    // Mask register: loaded by a configuration mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (mask_hit) mask_q <= mask_d;
    end

    // Pending register: loaded by the user pending strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= '0;
        else if (pend_hit) pend_q <= pend_d;
    end

    // Change detect: the write hits an enabled function and alters its mask.
    always_comb mask_chg = mask_hit && en_q && (mask_d != mask_q);

endmodule

// File: rtl/msi_rd_port.sv
// Module: msi_rd_port
// Registered read-back of one function's mask and pending word, selected
// by index. It uses an AND-OR mux, so an index of NUM_FN or more reads zero.
// Assumes: flat buses are packed with function f at bits [VEC_W*f +: VEC_W].
module msi_rd_port #(
    parameter int unsigned NUM_FN   = 12,
    parameter int unsigned FN_IDX_W = 4,
    parameter int unsigned VEC_W    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FN_IDX_W-1:0]     sel,
    input  logic [NUM_FN*VEC_W-1:0] mask_flat,
    input  logic [NUM_FN*VEC_W-1:0] pend_flat,
    output logic [VEC_W-1:0]        mask_rd,
    output logic [VEC_W-1:0]        pend_rd
);

    logic [NUM_FN-1:0] hit;
    logic [VEC_W-1:0]  mask_mux;
    logic [VEC_W-1:0]  pend_mux;

    for (genvar g = 0; g < NUM_FN; g++) begin : g_sel
        // Decode the select index into a one-hot hit vector.
        always_comb hit[g] = (sel == FN_IDX_W'(g));
    end

    // Select the addressed words; no hit gives zero.
    always_comb begin
        mask_mux = '0;
        pend_mux = '0;
        for (int i = 0; i < NUM_FN; i++) begin
            mask_mux |= mask_flat[VEC_W*i +: VEC_W] & {VEC_W{hit[i]}};
            pend_mux |= pend_flat[VEC_W*i +: VEC_W] & {VEC_W{hit[i]}};
        end
    end

    // Output stage that gives the fixed one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_rd <= '0;
            pend_rd <= '0;
        end else begin
            mask_rd <= mask_mux;
            pend_rd <= pend_mux;
        end
    end

endmodule

// File: rtl/msi_cap_bank.sv
// Module: msi_cap_bank (top)
// MSI capability state bank for NUM_FN physical functions. It contains the
// write decoder, one state slice per function, the select read-back port and
// the mask-change notification pulse.
// Assumes: NUM_FN <= 2**FN_IDX_W, VEC_W >= 4, and one configuration write
// per cycle.
module msi_cap_bank
    import msi_cap_pkg::*;
#(
    parameter int unsigned NUM_FN   = 12,
    parameter int unsigned FN_IDX_W = 4,
    parameter int unsigned VEC_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr_en_i,
    input  logic                      cfg_wr_kind_i,
    input  logic [FN_IDX_W-1:0]       cfg_wr_fn_i,
    input  logic [VEC_W-1:0]          cfg_wr_data_i,
    input  logic                      pend_we_i,
    input  logic [FN_IDX_W-1:0]       pend_fn_i,
    input  logic [VEC_W-1:0]          pend_data_i,
    input  logic [FN_IDX_W-1:0]       mask_sel_i,
    output logic [NUM_FN-1:0]         msi_en_o,
    output logic [MME_W*NUM_FN-1:0]   mme_o,
    output logic [VEC_W-1:0]          mask_rdata_o,
    output logic [VEC_W-1:0]          pend_rdata_o,
    output logic                      mask_upd_o
);

    localparam int unsigned FLAT_W = NUM_FN * VEC_W;

    logic [NUM_FN-1:0] ctrl_hit;
    logic [NUM_FN-1:0] mask_hit;
    logic [NUM_FN-1:0] pend_hit;
    logic [NUM_FN-1:0] mask_chg;
    logic              ctrl_en;
    logic [MME_W-1:0]  ctrl_mme;
    logic [FLAT_W-1:0] mask_flat;
    logic [FLAT_W-1:0] pend_flat;

    msi_cfg_decode #(
        .NUM_FN   (NUM_FN),
        .FN_IDX_W (FN_IDX_W)
    ) u_dec (
        .wr_en      (cfg_wr_en_i),
        .wr_kind    (cfg_wr_kind_i),
        .wr_fn      (cfg_wr_fn_i),
        .ctrl_field (cfg_wr_data_i[3:0]),
        .pend_we    (pend_we_i),
        .pend_fn    (pend_fn_i),
        .ctrl_hit   (ctrl_hit),
        .mask_hit   (mask_hit),
        .pend_hit   (pend_hit),
        .ctrl_en    (ctrl_en),
        .ctrl_mme   (ctrl_mme)
    );

    for (genvar g = 0; g < NUM_FN; g++) begin : g_slice
        msi_fn_slice #(
            .VEC_W (VEC_W)
        ) u_fn (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_hit (ctrl_hit[g]),
            .mask_hit (mask_hit[g]),
            .pend_hit (pend_hit[g]),
            .en_d     (ctrl_en),
            .mme_d    (ctrl_mme),
            .mask_d   (cfg_wr_data_i),
            .pend_d   (pend_data_i),
            .en_q     (msi_en_o[g]),
            .mme_q    (mme_o[MME_W*g +: MME_W]),
            .mask_q   (mask_flat[VEC_W*g +: VEC_W]),
            .pend_q   (pend_flat[VEC_W*g +: VEC_W]),
            .mask_chg (mask_chg[g])
        );
    end

    msi_rd_port #(
        .NUM_FN   (NUM_FN),
        .FN_IDX_W (FN_IDX_W),
        .VEC_W    (VEC_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (mask_sel_i),
        .mask_flat (mask_flat),
        .pend_flat (pend_flat),
        .mask_rd   (mask_rdata_o),
        .pend_rd   (pend_rdata_o)
    );

    // Notification pulse: one cycle after any enabled mask changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_upd_o <= 1'b0;
        else        mask_upd_o <= |mask_chg;
    end

endmodule

// File: rtl/msi_cap_bank_chk.sv
// Module: msi_cap_bank_chk
// Property checker for msi_cap_bank. It only observes ports and is attached
// to the top module through the bind statement below.
module msi_cap_bank_chk #(
    parameter int unsigned NUM_FN   = 12,
    parameter int unsigned FN_IDX_W = 4,
    parameter int unsigned VEC_W    = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr_en_i,
    input logic                  cfg_wr_kind_i,
    input logic [FN_IDX_W-1:0]   mask_sel_i,
    input logic [NUM_FN-1:0]     msi_en_o,
    input logic [3*NUM_FN-1:0]   mme_o,
    input logic [VEC_W-1:0]      mask_rdata_o,
    input logic [VEC_W-1:0]      pend_rdata_o,
    input logic                  mask_upd_o
);

    logic sel_oob;

    // Flag a select index that names no function.
    always_comb sel_oob = ({1'b0, mask_sel_i} >= (FN_IDX_W+1)'(NUM_FN));

    for (genvar g = 0; g < NUM_FN; g++) begin : g_legal
        // R3: a stored code never exceeds 5.
        p_mme_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
            mme_o[3*g +: 3] <= 3'd5);
    end

    // R2: enables change only after a configuration write.
    p_en_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr_en_i) |-> $stable(msi_en_o));

    // R2: multiple-message fields change only after a configuration write.
    p_mme_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_wr_en_i) |-> $stable(mme_o));

    // R6: a pulse is always preceded by a mask write.
    p_upd_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_upd_o |-> $past(cfg_wr_en_i && cfg_wr_kind_i));

    // R9: an out-of-range select reads zero on both outputs.
    p_oob_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_oob) |-> (mask_rdata_o == '0 && pend_rdata_o == '0));

endmodule

bind msi_cap_bank msi_cap_bank_chk #(
    .NUM_FN   (NUM_FN),
    .FN_IDX_W (FN_IDX_W),
    .VEC_W    (VEC_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en_i   (cfg_wr_en_i),
    .cfg_wr_kind_i (cfg_wr_kind_i),
    .mask_sel_i    (mask_sel_i),
    .msi_en_o      (msi_en_o),
    .mme_o         (mme_o),
    .mask_rdata_o  (mask_rdata_o),
    .pend_rdata_o  (pend_rdata_o),
    .mask_upd_o    (mask_upd_o)
);

// File: tb/sim_msi_cap_bank.sv
// Bench for msi_cap_bank: sweeps every function index (including indices out
// of range) through control, mask, pending and read-back traffic against an
// arithmetic model. Inputs are driven and outputs sampled on falling edges.
module sim_msi_cap_bank;

    localparam int NF = 12;
    localparam int IW = 4;
    localparam int VW = 32;
    localparam int NI = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en_i = 1'b0;
    logic          cfg_wr_kind_i = 1'b0;
    logic [IW-1:0] cfg_wr_fn_i = '0;
    logic [VW-1:0] cfg_wr_data_i = '0;
    logic          pend_we_i = 1'b0;
    logic [IW-1:0] pend_fn_i = '0;
    logic [VW-1:0] pend_data_i = '0;
    logic [IW-1:0] mask_sel_i = '0;
    logic [NF-1:0]   msi_en_o;
    logic [3*NF-1:0] mme_o;
    logic [VW-1:0]   mask_rdata_o;
    logic [VW-1:0]   pend_rdata_o;
    logic            mask_upd_o;

    int total = 0;
    int bad = 0;

    logic          en_m   [NI];
    logic [2:0]    mme_m  [NI];
    logic [VW-1:0] mask_m [NI];
    logic [VW-1:0] pend_m [NI];

    always #2 clk = ~clk;

    msi_cap_bank #(.NUM_FN(NF), .FN_IDX_W(IW), .VEC_W(VW)) u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [NF-1:0] en_vec();
        logic [NF-1:0] v;
        for (int i = 0; i < NF; i++) v[i] = en_m[i];
        return v;
    endfunction

    function automatic logic [3*NF-1:0] mme_vec();
        logic [3*NF-1:0] v;
        for (int i = 0; i < NF; i++) v[3*i +: 3] = mme_m[i];
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NI; i++) begin
            en_m[i] = 1'b0; mme_m[i] = '0; mask_m[i] = '0; pend_m[i] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Control write: enable in bit 0, code in bits [3:1]; checked one cycle later.
    task automatic ctrl_wr(input int fn, input logic en, input logic [2:0] code);
        @(negedge clk);
        cfg_wr_en_i = 1'b1; cfg_wr_kind_i = 1'b0;
        cfg_wr_fn_i = IW'(fn); cfg_wr_data_i = {28'h5A5A5A0, code, en};
        if (fn < NF) begin
            en_m[fn]  = en;
            mme_m[fn] = (code > 3'd5) ? 3'd5 : code;
        end
        @(negedge clk);
        cfg_wr_en_i = 1'b0;
        chk("R2/R9/R10 enables", 64'(msi_en_o), 64'(en_vec()));
        chk("R3/R9/R10 mme", 64'(mme_o), 64'(mme_vec()));
    endtask

    // Mask write; the pulse is expected in the cycle right after it, then low.
    task automatic mask_wr(input int fn, input logic [VW-1:0] d);
        logic exp;
        exp = (fn < NF) && en_m[fn] && (d != mask_m[fn]);
        @(negedge clk);
        cfg_wr_en_i = 1'b1; cfg_wr_kind_i = 1'b1;
        cfg_wr_fn_i = IW'(fn); cfg_wr_data_i = d;
        if (fn < NF) mask_m[fn] = d;
        @(negedge clk);
        cfg_wr_en_i = 1'b0;
        chk(exp ? "R6 pulse" : "R7 no pulse", 64'(mask_upd_o), 64'(exp));
        @(negedge clk);
        chk("R6 single cycle", 64'(mask_upd_o), 64'd0);
    endtask

    task automatic pend_wr(input int fn, input logic [VW-1:0] d);
        @(negedge clk);
        pend_we_i = 1'b1; pend_fn_i = IW'(fn); pend_data_i = d;
        if (fn < NF) pend_m[fn] = d;
        @(negedge clk);
        pend_we_i = 1'b0;
    endtask

    // Read one index; data is valid one cycle after the select.
    task automatic rd_chk(input int fn, input string req);
        logic [VW-1:0] em, ep;
        em = (fn < NF) ? mask_m[fn] : '0;
        ep = (fn < NF) ? pend_m[fn] : '0;
        @(negedge clk);
        mask_sel_i = IW'(fn);
        @(negedge clk);
        chk({req, " mask"}, 64'(mask_rdata_o), 64'(em));
        chk({req, " pend"}, 64'(pend_rdata_o), 64'(ep));
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();
        // R1: reset state at the ports.
        chk("R1 enables", 64'(msi_en_o), 64'd0);
        chk("R1 mme", 64'(mme_o), 64'd0);
        chk("R1 pulse", 64'(mask_upd_o), 64'd0);
        chk("R1 mask rd", 64'(mask_rdata_o), 64'd0);
        for (int f = 0; f < NI; f++) rd_chk(f, "R1 swept");

        // R2/R3/R9/R10: every code to every index, then a final setting.
        for (int f = 0; f < NI; f++)
            for (int c = 0; c < 8; c++) ctrl_wr(f, c[0], 3'(c));
        for (int f = 0; f < NI; f++) ctrl_wr(f, ~f[0], 3'(f % 6));

        // R4/R6/R7: first write, repeated write, changed write.
        for (int f = 0; f < NI; f++) begin
            mask_wr(f, 32'h1 << f ^ {8'(f), 24'hC3A500});
            mask_wr(f, 32'h1 << f ^ {8'(f), 24'hC3A500});
            mask_wr(f, ~(32'h1 << f));
        end

        // R8/R9: pending strobes to every index.
        for (int f = 0; f < NI; f++) pend_wr(f, {16'(f * 37), 16'hBEEF} ^ (32'h80000000 >> f));

        // R4/R5/R8/R9/R10: read every index back.
        for (int f = 0; f < NI; f++) rd_chk(f, "R5 R8 R9 readback");
        for (int f = NI - 1; f >= 0; f--) rd_chk(f, "R5 reverse order");

        // R1: a second reset clears everything again.
        do_reset();
        chk("R1 enables after rerun", 64'(msi_en_o), 64'd0);
        chk("R1 mme after rerun", 64'(mme_o), 64'd0);
        for (int f = 0; f < NF; f++) rd_chk(f, "R1 cleared");

        finish_run();
    end

endmodule